// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block sits beside the command bus of a four-bank double-data-rate SDRAM device and inspects it on every rising clock edge. It turns the clock-enable level, chip select, the row/column/write strobes, the bank address and the auto-precharge address bit into one decoded command. It keeps a small model of the device: an open or idle flag per bank, an auto-precharge burst counter per bank, a settle counter that follows mode register writes, and a self-refresh flag. Each command is judged against that model. An illegal command is reported with a one-cycle violation pulse and an error code, and the model is left untouched.

The checker is passive. It drives nothing back onto the bus and applies no back-pressure. All outputs are registered. They describe the command sampled at the most recent rising edge and the model state after that edge. The burst length select is a static configuration input. It sets how long an auto-precharge access keeps its bank busy.

Top module: `ddr_cmd_checker`

## Requirements
- R1: With clock enable high in the previous and the current cycle and chip select low, the strobe pattern {ras_n,cas_n,we_n} decodes as follows on `cmd_o`: 111 NOP=0, 011 activate=7, 101 read=8, 100 write=9, 110 burst stop=10, 010 precharge=11, 001 refresh=4, 000 with bank 0 mode set=2, 000 with bank 1 extended mode set=3, 000 with bank 2 or 3 reserved=13. Chip select high decodes as deselect=1.
- R2: `bank_o` repeats the bank address of the sampled command. Bit i of `bank_open_o` is the state of the bank addressed by ba=i (ba 00, 01, 10 and 11 are the four banks).
- R3: A mode set or extended mode set is legal only while every bank is idle. Otherwise it raises error code 1.
- R4: During the two cycles after a legal mode set or extended mode set, any command other than NOP or deselect raises error code 2.
- R5: A refresh, or a self-refresh entry, raises error code 1 while any bank is open.
- R6: A legal precharge with a10 high closes every bank whatever ba holds. With a10 low it closes only the addressed bank.
- R7: Activating a bank that is already open raises code 4. A read or write to an idle bank raises code 5.
- R8: A legal read or write with a10 high closes its bank by itself N cycles after the command edge. N is 1, 2 or 4 for burst select 00, 01 or 10/11.
- R9: While a write with auto-precharge is in its N-cycle window, any read or write to any bank raises code 3. After the window, read and write to another bank are legal again.
- R10: An activate, read, write or precharge that touches a bank whose auto-precharge is still pending raises code 7.
- R11: Burst stop is legal in every state outside the mode-set settle window and changes no bank state.
- R12: Clock enable falling together with the refresh pattern is self-refresh entry (cmd 5) and sets `self_ref_o`. While clock enable stays low, every cycle decodes as power-down (cmd 12) and bank state does not change. The first cycle with clock enable high again decodes as wake (cmd 6) and clears `self_ref_o`.
- R13: The reserved pattern raises code 6. Any rejected command leaves bank state unchanged. `viol_o` is high for exactly the cycles whose `viol_code_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank address bit |
| burst_sel | input | 2 | Static burst length select: 00=2, 01=4, 10/11=8 |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Bank address of the decoded command |
| bank_open_o | output | 2**BA_W | Per-bank open flags |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Error code, 0 when legal |
| self_ref_o | output | 1 | Device is in self-refresh |

## Verification
The hardest situation to reach is the overlap of a write auto-precharge window with its own closing edge. A second access must land in the last cycle of the window, exactly when the bank closes on its own. The stimulus opens a bank, issues the write with a10 high, and then places a read to the same bank and a write to an idle bank on the next two edges. The second of these coincides with the close. The same bank is then reused with a read auto-precharge, and the auto-precharge sequence is repeated at the shortest and the longest burst select. This shows that the window length follows the select and that a pending read precharge blocks the bank without locking the others.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_EMRS  = 4'd3,
    CMD_REF   = 4'd4,
    CMD_SREF  = 4'd5,
    CMD_WAKE  = 4'd6,
    CMD_ACT   = 4'd7,
    CMD_RD    = 4'd8,
    CMD_WR    = 4'd9,
    CMD_BST   = 4'd10,
    CMD_PRE   = 4'd11,
    CMD_PDN   = 4'd12,
    CMD_RSVD  = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NOT_IDLE = 3'd1,
    ERR_SETTLE   = 3'd2,
    ERR_WR_LOCK  = 3'd3,
    ERR_ACT_OPEN = 3'd4,
    ERR_ACC_IDLE = 3'd5,
    ERR_RSVD     = 3'd6,
    ERR_AP_PEND  = 3'd7
  } err_e;

endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
  import ddrchk_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_now_i,
  input  logic            cke_prev_i,
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BA_W-1:0] ba_i,
  output cmd_e            cmd_o
);

  logic [2:0] strobes;
  assign strobes = {ras_n_i, cas_n_i, we_n_i};

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_prev_i) begin
      cmd_o = cke_now_i ? CMD_WAKE : CMD_PDN;
    end else if (!cke_now_i) begin
      cmd_o = (!cs_n_i && strobes == 3'b001) ? CMD_SREF : CMD_PDN;
    end else if (cs_n_i) begin
      cmd_o = CMD_DESEL;
    end else begin
      case (strobes)
        3'b000: begin
          if (ba_i[BA_W-1:1] != '0) cmd_o = CMD_RSVD;
          else                      cmd_o = ba_i[0] ? CMD_EMRS : CMD_MRS;
        end
        3'b001:  cmd_o = CMD_REF;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddrchk_bank_slot.sv
module ddrchk_bank_slot #(
  parameter int AP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic            pre_i,
  input  logic            ap_load_i,
  input  logic            ap_wr_i,
  input  logic [AP_W-1:0] ap_len_i,
  output logic            open_o,
  output logic            pend_o,
  output logic            wr_pend_o
);

  logic            open_q;
  logic            wr_q;
  logic [AP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ap_load_i) begin
        cnt_q <= ap_len_i;
        wr_q  <= ap_wr_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - AP_W'(1);
        if (cnt_q == AP_W'(1)) begin
          open_q <= 1'b0;
          wr_q   <= 1'b0;
        end
      end
      if (act_i)      open_q <= 1'b1;
      else if (pre_i) open_q <= 1'b0;
    end
  end

  assign open_o    = open_q;
  assign pend_o    = (cnt_q != '0);
  assign wr_pend_o = wr_q && (cnt_q != '0);

  AST_ACT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && cnt_q == '0)); // R7
  AST_AP_SELF_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == AP_W'(1) && !ap_load_i && !act_i) |=> !open_q); // R8

endmodule

// File: rtl/ddrchk_rules.sv
module ddrchk_rules
  import ddrchk_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int MRS_GAP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [(1<<BA_W)-1:0] open_i,
  input  logic [(1<<BA_W)-1:0] pend_i,
  input  logic [(1<<BA_W)-1:0] wr_pend_i,
  output logic                 legal_o,
  output err_e                 code_o
);

  localparam int GAP_W = $clog2(MRS_GAP + 1);

  logic [GAP_W-1:0] gap_q;
  err_e             verdict;
  logic             sel_open;
  logic             sel_pend;

  assign sel_open = open_i[ba_i];
  assign sel_pend = pend_i[ba_i];

  always_comb begin
    verdict = ERR_NONE;
    if (gap_q != '0 && !(cmd_i inside {CMD_NOP, CMD_DESEL})) begin
      verdict = ERR_SETTLE;
    end else begin
      case (cmd_i)
        CMD_RSVD: verdict = ERR_RSVD;
        CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF: begin
          if (|open_i) verdict = ERR_NOT_IDLE;
        end
        CMD_ACT: begin
          if (sel_pend)      verdict = ERR_AP_PEND;
          else if (sel_open) verdict = ERR_ACT_OPEN;
        end
        CMD_RD, CMD_WR: begin
          if (|wr_pend_i)     verdict = ERR_WR_LOCK;
          else if (sel_pend)  verdict = ERR_AP_PEND;
          else if (!sel_open) verdict = ERR_ACC_IDLE;
        end
        CMD_PRE: begin
          if (a10_i ? (|pend_i) : sel_pend) verdict = ERR_AP_PEND;
        end
        default: verdict = ERR_NONE;
      endcase
    end
  end

  assign code_o  = verdict;
  assign legal_o = (verdict == ERR_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (legal_o && (cmd_i inside {CMD_MRS, CMD_EMRS})) begin
      gap_q <= GAP_W'(MRS_GAP);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - GAP_W'(1);
    end
  end

  AST_WR_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_pend_i) && (cmd_i inside {CMD_RD, CMD_WR})) |-> !legal_o); // R9

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddrchk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int MAX_BURST = 8,
  parameter int MRS_GAP   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [1:0]           burst_sel,
  output logic [3:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [(1<<BA_W)-1:0] bank_open_o,
  output logic                 viol_o,
  output logic [2:0]           viol_code_o,
  output logic                 self_ref_o
);

  localparam int NB   = 1 << BA_W;
  localparam int AP_W = $clog2(MAX_BURST / 2 + 1);

  logic            cke_prev_q;
  logic            sref_q;
  cmd_e            cmd_now;
  cmd_e            cmd_q;
  err_e            code_now;
  err_e            code_q;
  logic            legal_now;
  logic            viol_q;
  logic [BA_W-1:0] bank_q;
  logic [NB-1:0]   open_v;
  logic [NB-1:0]   pend_v;
  logic [NB-1:0]   wrp_v;
  logic [AP_W-1:0] ap_len;
  logic            is_access;

  ddrchk_decode #(.BA_W(BA_W)) u_decode (
    .cke_now_i (cke),
    .cke_prev_i(cke_prev_q),
    .cs_n_i    (cs_n),
    .ras_n_i   (ras_n),
    .cas_n_i   (cas_n),
    .we_n_i    (we_n),
    .ba_i      (ba),
    .cmd_o     (cmd_now)
  );

  ddrchk_rules #(.BA_W(BA_W), .MRS_GAP(MRS_GAP)) u_rules (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_now),
    .ba_i     (ba),
    .a10_i    (a10),
    .open_i   (open_v),
    .pend_i   (pend_v),
    .wr_pend_i(wrp_v),
    .legal_o  (legal_now),
    .code_o   (code_now)
  );

  always_comb begin
    case (burst_sel)
      2'b00:   ap_len = AP_W'(1);
      2'b01:   ap_len = AP_W'(2);
      default: ap_len = AP_W'(MAX_BURST / 2);
    endcase
  end

  assign is_access = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(i));
    ddrchk_bank_slot #(.AP_W(AP_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (legal_now && cmd_now == CMD_ACT && hit),
      .pre_i    (legal_now && cmd_now == CMD_PRE && (a10 || hit)),
      .ap_load_i(legal_now && is_access && a10 && hit),
      .ap_wr_i  (cmd_now == CMD_WR),
      .ap_len_i (ap_len),
      .open_o   (open_v[i]),
      .pend_o   (pend_v[i]),
      .wr_pend_o(wrp_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b1;
      sref_q     <= 1'b0;
      cmd_q      <= CMD_NOP;
      code_q     <= ERR_NONE;
      viol_q     <= 1'b0;
      bank_q     <= '0;
    end else begin
      cke_prev_q <= cke;
      if (cmd_now == CMD_SREF && legal_now) sref_q <= 1'b1;
      else if (cmd_now == CMD_WAKE)         sref_q <= 1'b0;
      cmd_q  <= cmd_now;
      code_q <= code_now;
      viol_q <= !legal_now;
      bank_q <= ba;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_o      = bank_q;
  assign bank_open_o = open_v;
  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
  assign self_ref_o  = sref_q;

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q inside {CMD_MRS, CMD_EMRS}) && !viol_q)
      |=> ((cmd_q inside {CMD_NOP, CMD_DESEL}) || viol_q)); // R4
  AST_MODE_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q inside {CMD_MRS, CMD_EMRS, CMD_REF}) && !viol_q) |-> (open_v == '0)); // R3
  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_now == CMD_PRE && legal_now && a10) |=> (open_v == '0)); // R6
  AST_VIOL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!legal_now) |=> (viol_o && viol_code_o != 3'd0)); // R13

endmodule

// File: tb/ddr_cmd_checker_tb.sv
`timescale 1ns/1ps
module ddr_cmd_checker_tb;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_DES = 4'b1111;
  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba = 2'b00;
  logic       a10 = 1'b0;
  logic [1:0] burst_sel = 2'b01;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic [3:0] bank_open_o;
  logic       viol_o;
  logic [2:0] viol_code_o;
  logic       self_ref_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] cmd;
    logic [1:0] bank;
    logic [2:0] code;
    logic [3:0] open;
    logic       sref;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;

  ddr_cmd_checker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .burst_sel(burst_sel),
    .cmd_o(cmd_o), .bank_o(bank_o), .bank_open_o(bank_open_o),
    .viol_o(viol_o), .viol_code_o(viol_code_o), .self_ref_o(self_ref_o)
  );

  task automatic drive(input logic k, input logic [3:0] pat, input logic [1:0] b,
                       input logic ap, input logic [3:0] ec, input logic [2:0] ecode,
                       input logic [3:0] eo, input logic es, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = pat;
    ba = b;
    a10 = ap;
    e.cmd = ec; e.bank = b; e.code = ecode; e.open = eo; e.sref = es; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      checks++;
      if (cmd_o !== cur.cmd || bank_o !== cur.bank || viol_code_o !== cur.code ||
          viol_o !== (cur.code != 3'd0) || bank_open_o !== cur.open ||
          self_ref_o !== cur.sref) begin
        errors++;
        $display("FAIL %s: got cmd=%0d bank=%0d viol=%b code=%0d open=%b sref=%b exp cmd=%0d bank=%0d code=%0d open=%b sref=%b",
                 cur.tag, cmd_o, bank_o, viol_o, viol_code_o, bank_open_o, self_ref_o,
                 cur.cmd, cur.bank, cur.code, cur.open, cur.sref);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (cmd_o !== 4'd0 || viol_o !== 1'b0 || viol_code_o !== 3'd0 ||
        bank_open_o !== 4'b0000 || self_ref_o !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset: got cmd=%0d viol=%b open=%b sref=%b exp 0 0 0000 0",
               cmd_o, viol_o, bank_open_o, self_ref_o);
    end

    // mode set and settle window
    drive(1, P_MRS, 2'd0, 0, 4'd2,  3'd0, 4'b0000, 0, "R1 R3 mode set idle");
    drive(1, P_ACT, 2'd0, 0, 4'd7,  3'd2, 4'b0000, 0, "R4 act in settle");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R4 nop in settle");
    drive(1, P_ACT, 2'd0, 0, 4'd7,  3'd0, 4'b0001, 0, "R4 act after settle");
    drive(1, P_MRS, 2'd0, 0, 4'd2,  3'd1, 4'b0001, 0, "R3 mode set with open bank");
    drive(1, P_REF, 2'd0, 0, 4'd4,  3'd1, 4'b0001, 0, "R5 refresh with open bank");
    drive(1, P_ACT, 2'd0, 0, 4'd7,  3'd4, 4'b0001, 0, "R7 act on open");
    drive(1, P_RD,  2'd1, 0, 4'd8,  3'd5, 4'b0001, 0, "R7 read on idle");
    drive(1, P_ACT, 2'd2, 0, 4'd7,  3'd0, 4'b0101, 0, "R2 act bank 2");
    drive(1, P_BST, 2'd0, 0, 4'd10, 3'd0, 4'b0101, 0, "R11 burst stop");
    drive(1, P_PRE, 2'd0, 0, 4'd11, 3'd0, 4'b0100, 0, "R6 single precharge");
    drive(1, P_ACT, 2'd3, 0, 4'd7,  3'd0, 4'b1100, 0, "R2 act bank 3");
    drive(1, P_PRE, 2'd1, 1, 4'd11, 3'd0, 4'b0000, 0, "R6 precharge all");
    // write auto-precharge window, burst 4
    drive(1, P_ACT, 2'd1, 0, 4'd7,  3'd0, 4'b0010, 0, "R2 act bank 1");
    drive(1, P_WR,  2'd1, 1, 4'd9,  3'd0, 4'b0010, 0, "R8 write auto-precharge");
    drive(1, P_RD,  2'd1, 0, 4'd8,  3'd3, 4'b0010, 0, "R9 read in write lock");
    drive(1, P_WR,  2'd2, 0, 4'd9,  3'd3, 4'b0000, 0, "R9 R8 write in lock at close");
    drive(1, P_ACT, 2'd2, 0, 4'd7,  3'd0, 4'b0100, 0, "R9 act after lock");
    drive(1, P_WR,  2'd2, 0, 4'd9,  3'd0, 4'b0100, 0, "R9 write other bank after lock");
    drive(1, P_RD,  2'd2, 1, 4'd8,  3'd0, 4'b0100, 0, "R8 read auto-precharge");
    drive(1, P_ACT, 2'd2, 0, 4'd7,  3'd7, 4'b0100, 0, "R10 act on pending bank");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R8 close after 2");
    // burst 2
    burst_sel = 2'b00;
    drive(1, P_ACT, 2'd0, 0, 4'd7,  3'd0, 4'b0001, 0, "R2 act bank 0");
    drive(1, P_RD,  2'd0, 1, 4'd8,  3'd0, 4'b0001, 0, "R8 read ap burst 2");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R8 close after 1");
    // burst 8
    burst_sel = 2'b10;
    drive(1, P_ACT, 2'd3, 0, 4'd7,  3'd0, 4'b1000, 0, "R2 act bank 3");
    drive(1, P_RD,  2'd3, 1, 4'd8,  3'd0, 4'b1000, 0, "R8 read ap burst 8");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b1000, 0, "R8 open 1");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b1000, 0, "R8 open 2");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b1000, 0, "R8 open 3");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R8 close after 4");
    // reserved and extended mode set
    drive(1, P_MRS, 2'd2, 0, 4'd13, 3'd6, 4'b0000, 0, "R13 reserved");
    drive(1, P_MRS, 2'd1, 0, 4'd3,  3'd0, 4'b0000, 0, "R1 extended mode set");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R4 nop gap");
    drive(1, P_BST, 2'd0, 0, 4'd10, 3'd2, 4'b0000, 0, "R4 burst stop in settle");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R1 nop");
    // self-refresh and power-down
    drive(0, P_REF, 2'd0, 0, 4'd5,  3'd0, 4'b0000, 1, "R12 self-refresh entry");
    drive(0, P_ACT, 2'd0, 0, 4'd12, 3'd0, 4'b0000, 1, "R12 act ignored in cke low");
    drive(1, P_NOP, 2'd0, 0, 4'd6,  3'd0, 4'b0000, 0, "R12 wake");
    drive(1, P_ACT, 2'd0, 0, 4'd7,  3'd0, 4'b0001, 0, "R2 act bank 0");
    drive(0, P_REF, 2'd0, 0, 4'd5,  3'd1, 4'b0001, 0, "R5 self-refresh with open bank");
    drive(1, P_NOP, 2'd0, 0, 4'd6,  3'd0, 4'b0001, 0, "R12 wake from power-down");
    drive(1, P_DES, 2'd0, 0, 4'd1,  3'd0, 4'b0001, 0, "R1 deselect");
    drive(1, P_PRE, 2'd0, 1, 4'd11, 3'd0, 4'b0000, 0, "R6 precharge all");
    drive(1, P_REF, 2'd0, 0, 4'd4,  3'd0, 4'b0000, 0, "R5 refresh all idle");
    drive(1, P_NOP, 2'd0, 0, 4'd0,  3'd0, 4'b0000, 0, "R1 final nop");

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule